// File: doc/BRIEF.md
# Banked GPIO with edge interrupts

This peripheral serves one bank of general-purpose pins. Software writes a direction mask to choose which pins are driven. It changes the driven levels through a set register and a clear register. Both are write-one-only, so setting or clearing one pin never needs a read-modify-write. Every pin level is brought into the clock domain through a flip-flop synchronizer, and the synchronized level can be read back at any time, also for pins that are being driven.

Rising and falling transitions of the synchronized pins can latch bits in a sticky status register. Each transition kind has its own enable mask, and each mask has its own set and clear registers. The pins are split into groups of sixteen. Each group has one level-sensitive interrupt output, which is high while any status bit of that group is set and that group's bit in the bank enable register is 1. Software clears a status bit by writing 1 to it.

Top module: `gpio_bank`

## Requirements
- R1: During and after synchronous reset: all pins are inputs (pin_oe = 0, direction register reads all ones), pin_out = 0, both edge masks = 0, status = 0, bank enable = 0, irq = 0 and bus_rdata = 0.
- R2: Direction bit 1 makes the pin an input and bit 0 makes it an output. pin_oe is the bitwise inverse of the direction register and changes only on a write to offset 0x10.
- R3: Writing to 0x18 sets each output bit written as 1, and writing to 0x1C clears each output bit written as 1. Bits written as 0 keep their value. The output latch drives pin_out and reads back at 0x14.
- R4: Offset 0x20 returns the pin level after a two-stage synchronizer, whatever the direction. A pin change applied before clock edge k is first returned by a read whose data is registered at edge k+2.
- R5: The rising mask is set bitwise by writing 1s to 0x24 and cleared bitwise by writing 1s to 0x28. Both offsets read the rising mask. The falling mask works the same way at 0x2C and 0x30.
- R6: A 0-to-1 transition of a synchronized pin whose rising-mask bit is 1 latches its status bit, and a 1-to-0 transition with the falling-mask bit set does the same. A transition whose mask bit is 0 latches nothing. Status reads at 0x34.
- R7: Writing 1 to a status bit at 0x34 clears it, and bits written as 0 are kept. If a new enabled transition is detected in the same cycle as the clear, the bit stays 1.
- R8: irq[g] is registered. It is 1 one cycle after status bits 16g..16g+15 are not all 0 while bank enable bit g (offset 0x08, bits [1:0]) is 1, and it is 0 otherwise.
- R9: Reads are registered with one cycle of latency. Offsets 0x18, 0x1C and every offset not named above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered from the previous cycle's address |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Drive enable, 1 = pin driven |
| irq | output | 2 | Level interrupt, one per group of 16 pins |

## Verification
The bench drives bit patterns through set and clear writes that overlap, so a design that overwrites the output latch instead of setting and clearing bits gives a different result. Pin patterns raise pins whose rising mask bit is 1, raise pins whose mask bit is 0, and lower pins with and without the falling mask, so edge polarity, mask gating and sticky latching can each be told apart. The bench issues a status clear in the same cycle as a detected edge and also with no edge present, which shows whether the set or the clear wins. It toggles the bank enable per group and watches for the interrupt appearing in the wrong group or at the wrong cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam logic [7:0] OFF_BEN  = 8'h08;
  localparam logic [7:0] OFF_DIR  = 8'h10;
  localparam logic [7:0] OFF_DOUT = 8'h14;
  localparam logic [7:0] OFF_SET  = 8'h18;
  localparam logic [7:0] OFF_CLR  = 8'h1C;
  localparam logic [7:0] OFF_DIN  = 8'h20;
  localparam logic [7:0] OFF_RSET = 8'h24;
  localparam logic [7:0] OFF_RCLR = 8'h28;
  localparam logic [7:0] OFF_FSET = 8'h2C;
  localparam logic [7:0] OFF_FCLR = 8'h30;
  localparam logic [7:0] OFF_STAT = 8'h34;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NPINS   = 32,
  parameter int GROUP_W = 16,
  localparam int NGROUPS = (NPINS + GROUP_W - 1) / GROUP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPINS-1:0]   lvl,
  input  logic [NPINS-1:0]   rise_mask,
  input  logic [NPINS-1:0]   fall_mask,
  input  logic [NPINS-1:0]   clr_vec,
  output logic [NPINS-1:0]   status,
  output logic [NGROUPS-1:0] grp_any
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] hit;

  assign hit = (lvl & ~prev_q & rise_mask) | (~lvl & prev_q & fall_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      status <= '0;
    end else begin
      prev_q <= lvl;
      status <= (status & ~clr_vec) | hit;
    end
  end

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    localparam int LO = g * GROUP_W;
    localparam int HI = ((LO + GROUP_W) > NPINS) ? NPINS : (LO + GROUP_W);
    assign grp_any[g] = |status[HI-1:LO];
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((status & $past(hit)) == $past(hit)));

  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr_vec & ~hit) != '0) |=> ((status & $past(clr_vec & ~hit)) == '0));

  // R6
  only_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int GROUP_W     = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NGROUPS    = (NPINS + GROUP_W - 1) / GROUP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [NPINS-1:0]   bus_wdata,
  output logic [NPINS-1:0]   bus_rdata,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  output logic [NGROUPS-1:0] irq
);
  logic [NPINS-1:0]   dir_q, dout_q, rmask_q, fmask_q;
  logic [NGROUPS-1:0] ben_q;
  logic [NPINS-1:0]   lvl, status, stat_clr, rd_d;
  logic [NGROUPS-1:0] grp_any;

  function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl)
  );

  assign stat_clr = (bus_wr && hit_addr(bus_addr, OFF_STAT)) ? bus_wdata : '0;

  gpio_edge_irq #(.NPINS(NPINS), .GROUP_W(GROUP_W)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl), .rise_mask(rmask_q), .fall_mask(fmask_q),
    .clr_vec(stat_clr), .status(status), .grp_any(grp_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '1;
      dout_q  <= '0;
      rmask_q <= '0;
      fmask_q <= '0;
      ben_q   <= '0;
    end else if (bus_wr) begin
      if (hit_addr(bus_addr, OFF_DIR))  dir_q   <= bus_wdata;
      if (hit_addr(bus_addr, OFF_SET))  dout_q  <= dout_q | bus_wdata;
      if (hit_addr(bus_addr, OFF_CLR))  dout_q  <= dout_q & ~bus_wdata;
      if (hit_addr(bus_addr, OFF_RSET)) rmask_q <= rmask_q | bus_wdata;
      if (hit_addr(bus_addr, OFF_RCLR)) rmask_q <= rmask_q & ~bus_wdata;
      if (hit_addr(bus_addr, OFF_FSET)) fmask_q <= fmask_q | bus_wdata;
      if (hit_addr(bus_addr, OFF_FCLR)) fmask_q <= fmask_q & ~bus_wdata;
      if (hit_addr(bus_addr, OFF_BEN))  ben_q   <= bus_wdata[NGROUPS-1:0];
    end
  end

  always_comb begin
    rd_d = '0;
    if (hit_addr(bus_addr, OFF_BEN))  rd_d = NPINS'(ben_q);
    if (hit_addr(bus_addr, OFF_DIR))  rd_d = dir_q;
    if (hit_addr(bus_addr, OFF_DOUT)) rd_d = dout_q;
    if (hit_addr(bus_addr, OFF_DIN))  rd_d = lvl;
    if (hit_addr(bus_addr, OFF_RSET) || hit_addr(bus_addr, OFF_RCLR)) rd_d = rmask_q;
    if (hit_addr(bus_addr, OFF_FSET) || hit_addr(bus_addr, OFF_FCLR)) rd_d = fmask_q;
    if (hit_addr(bus_addr, OFF_STAT)) rd_d = status;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= '0;
    end else begin
      bus_rdata <= rd_d;
      irq       <= grp_any & ben_q;
    end
  end

  assign pin_out = dout_q;
  assign pin_oe  = ~dir_q;

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(pin_out));

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && hit_addr(bus_addr, OFF_DIR)) |=> $stable(pin_oe));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq != '0) |-> (($past(ben_q) & irq) == irq));
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [1:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  gpio_bank u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #(PER/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] m_dir, m_dout, m_rm, m_fm, m_stat, m_rd, m_s1, m_s2, m_pv;
  logic [1:0]  m_ben, m_irq;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h08: return {30'd0, m_ben};
      8'h10: return m_dir;
      8'h14: return m_dout;
      8'h20: return m_s2;
      8'h24, 8'h28: return m_rm;
      8'h2C, 8'h30: return m_fm;
      8'h34: return m_stat;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a)
      8'h10: return "R2";
      8'h14: return "R3";
      8'h20: return "R4";
      8'h24, 8'h28, 8'h2C, 8'h30: return "R5";
      8'h34: return "R6";
      default: return "R9";
    endcase
  endfunction

  logic [7:0] m_last_addr;

  always @(posedge clk) begin
    if (rst) begin
      m_dir = '1; m_dout = '0; m_rm = '0; m_fm = '0; m_stat = '0; m_rd = '0;
      m_s1 = '0; m_s2 = '0; m_pv = '0; m_ben = '0; m_irq = '0; m_last_addr = '0;
    end else begin
      logic [31:0] hits, clr;
      hits = (m_s2 & ~m_pv & m_rm) | (~m_s2 & m_pv & m_fm);
      clr = (bus_wr && bus_addr == 8'h34) ? bus_wdata : 32'd0;
      m_rd = m_read(bus_addr);
      m_last_addr = bus_addr;
      m_irq = {(m_stat[31:16] != 0) && m_ben[1], (m_stat[15:0] != 0) && m_ben[0]};
      m_stat = (m_stat & ~clr) | hits;
      if (bus_wr) begin
        case (bus_addr)
          8'h08: m_ben = bus_wdata[1:0];
          8'h10: m_dir = bus_wdata;
          8'h18: m_dout = m_dout | bus_wdata;
          8'h1C: m_dout = m_dout & ~bus_wdata;
          8'h24: m_rm = m_rm | bus_wdata;
          8'h28: m_rm = m_rm & ~bus_wdata;
          8'h2C: m_fm = m_fm | bus_wdata;
          8'h30: m_fm = m_fm & ~bus_wdata;
          default: ;
        endcase
      end
      m_pv = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // model comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 model pin_oe", pin_oe, ~m_dir);
      chk("R3 model pin_out", pin_out, m_dout);
      chk("R8 model irq", {30'd0, irq}, {30'd0, m_irq});
      chk({rd_tag(m_last_addr), " model rdata"}, bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(PER * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pin_oe", pin_oe, 32'h0);
    chk("R1 reset rdata", bus_rdata, 32'h0);
    rst = 1'b0;
    chk("R1 reset pin_out", pin_out, 32'h0);
    chk("R1 reset irq", {30'd0, irq}, 32'h0);
    rd(8'h10, 32'hFFFF_FFFF, "R1 reset dir");
    rd(8'h24, 32'h0, "R1 reset rise mask");
    rd(8'h34, 32'h0, "R1 reset status");
    rd(8'h08, 32'h0, "R1 reset bank enable");

    // direction
    wr(8'h10, 32'hFFFF_0000);
    chk("R2 oe after dir write", pin_oe, 32'h0000_FFFF);
    rd(8'h10, 32'hFFFF_0000, "R2 dir readback");

    // set / clear data
    wr(8'h18, 32'h0000_00F3);
    wr(8'h1C, 32'h0000_0031);
    wr(8'h18, 32'h0);
    chk("R3 pin_out after set/clr", pin_out, 32'h0000_00C2);
    rd(8'h14, 32'h0000_00C2, "R3 output readback");
    wr(8'h1C, 32'h0);
    chk("R3 zero clear keeps", pin_out, 32'h0000_00C2);

    // input synchronizer latency
    bus_addr = 8'h20;
    @(negedge clk);
    pin_in = 32'h1234_5678;
    @(negedge clk);
    chk("R4 din old after 1 edge", bus_rdata, 32'h0);
    @(negedge clk);
    chk("R4 din old after 2 edges", bus_rdata, 32'h0);
    @(negedge clk);
    chk("R4 din new after 3 edges", bus_rdata, 32'h1234_5678);
    rd(8'h20, 32'h1234_5678, "R4 din on output pins too");

    // edge masks
    wr(8'h24, 32'h0000_0003);
    wr(8'h24, 32'h0001_0000);
    wr(8'h28, 32'h0000_0002);
    rd(8'h24, 32'h0001_0001, "R5 rise mask at set offset");
    rd(8'h28, 32'h0001_0001, "R5 rise mask at clear offset");
    wr(8'h2C, 32'h0002_0004);
    rd(8'h30, 32'h0002_0004, "R5 fall mask");

    // edge detection
    pin_in = 32'h1234_567B;
    idle(4);
    rd(8'h34, 32'h0000_0001, "R6 enabled rise latched, unmasked not");
    pin_in = 32'h1234_567F;
    idle(4);
    rd(8'h34, 32'h0000_0001, "R6 rise on fall-only pin ignored");
    pin_in = 32'h1234_567B;
    idle(4);
    rd(8'h34, 32'h0000_0005, "R6 fall latched");
    pin_in = 32'h1235_567B;
    idle(4);
    rd(8'h34, 32'h0001_0005, "R6 upper group rise latched");

    // interrupt gating
    chk("R8 irq blocked by bank enable", {30'd0, irq}, 32'h0);
    wr(8'h08, 32'h1);
    chk("R8 irq not yet", {30'd0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq group0", {30'd0, irq}, 32'h1);
    wr(8'h08, 32'h3);
    @(negedge clk);
    chk("R8 irq both groups", {30'd0, irq}, 32'h3);

    // W1C and set-wins
    wr(8'h34, 32'h0000_0004);
    rd(8'h34, 32'h0001_0001, "R7 w1c one bit");
    wr(8'h34, 32'h0001_0000);
    @(negedge clk);
    chk("R7 group1 irq drops", {30'd0, irq}, 32'h1);
    pin_in = 32'h1235_567A;
    idle(4);
    rd(8'h34, 32'h0000_0001, "R7 unmasked fall no change");
    pin_in = 32'h1235_567B;
    @(negedge clk);
    @(negedge clk);
    wr(8'h34, 32'h0000_0001);
    rd(8'h34, 32'h0000_0001, "R7 set wins over clear");
    wr(8'h34, 32'h0000_0001);
    rd(8'h34, 32'h0, "R7 clear without edge");
    @(negedge clk);
    chk("R8 irq clears", {30'd0, irq}, 32'h0);

    // unused and write-only offsets
    rd(8'h00, 32'h0, "R9 offset 0x00");
    rd(8'h3C, 32'h0, "R9 offset 0x3C");
    rd(8'h18, 32'h0, "R9 set-data reads 0");
    rd(8'h1C, 32'h0, "R9 clear-data reads 0");
    rd(8'h08, 32'h3, "R9 bank enable readback");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule